// File: doc/BRIEF.md
# Per-CPU Priority Pending Arbiter

This block looks across a vector of interrupt sources and, separately for each CPU interface, selects the most urgent source that is both enabled and pending for that CPU. It then reports the winner's ID and drives that CPU's interrupt request line. Each source has one 8-bit priority value, and a lower number means a more urgent source. Each CPU has its own enable and pending bit for every source, its own priority mask and its own running priority.

The selection uses two thresholds. The winner is reported as the highest-pending ID only when its priority is strictly below the CPU's priority mask. The request line rises only when the priority is also strictly below the CPU's running priority. An idle CPU has a running priority of 0x100, so any reportable winner can preempt it. When nothing qualifies, the reported ID is the spurious value 1023.

The block contains only the selection logic. Its outputs are registered one cycle after the inputs. A parameter chooses a balanced comparison tree or a linear scan; both give the same result.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Source s is a candidate for CPU c only when both `src_enable[c*NUM_SRC+s]` and `src_pending[c*NUM_SRC+s]` are 1. An enabled source that is not pending is never chosen, and neither is a pending source that is not enabled.
- R2: Among the candidates, the one with the numerically smallest priority wins. Source s has its priority in `src_prio[s*8 +: 8]`.
- R3: When several candidates share the smallest priority, the one with the lowest source ID wins.
- R4: When CPU c has no candidate, `hp_id[c*10 +: 10]` is 1023 and `cpu_irq[c]` is 0. Otherwise any reported ID is below NUM_SRC.
- R5: When `dist_en` is 0, every CPU reports 1023 and every request line is 0.
- R6: When `cpu_en[c]` is 0, CPU c reports 1023 with its request line at 0. The other CPUs are not affected.
- R7: The winner is reported only if its priority is strictly less than `prio_mask[c*8 +: 8]`. Otherwise the CPU reports 1023 with its request line at 0.
- R8: `cpu_irq[c]` is 1 only if the reported winner's priority, zero-extended to 9 bits, is strictly less than `run_prio[c*9 +: 9]`. With a running priority of 0x100, every reported winner raises the line.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, every ID is 1023 and every request line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| src_enable | input | NUM_CPU*NUM_SRC | Per-CPU, per-source enable bits |
| src_pending | input | NUM_CPU*NUM_SRC | Per-CPU, per-source pending bits |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, lower is more urgent |
| prio_mask | input | NUM_CPU*PRIO_W | Per-CPU priority mask |
| run_prio | input | NUM_CPU*(PRIO_W+1) | Per-CPU running priority, 0x100 when idle |
| hp_id | output | NUM_CPU*ID_W | Per-CPU highest-pending ID, 1023 if none |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench targets these corner cases:
- **Equal priorities.** A design that keeps the last equal source, rather than the first, reports a higher ID than R3 allows.
- **Threshold boundaries.** The bench sets the priority exactly equal to the mask and to the running priority, then one below each. A design that uses less-or-equal reports a masked source or raises a request it should not.
- **Idle running priority and per-CPU isolation.** It uses the idle value 0x100 with the least urgent maskable priority, and sets bits that are enabled but not pending or pending but not enabled. It also disables one CPU while another stays enabled, which exposes enable bits read from the wrong CPU and global gating applied per CPU.
- **Random sweep.** A long random sweep with few distinct priority values, so that ties are frequent, compares every output against an arithmetic model.
- **Latency.** A latency probe shows that the outputs hold until the next edge.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
   localparam int unsigned SPURIOUS_ID = 1023;
   localparam int unsigned MIN_ID_W    = 10;

   // strict compare: challenger replaces holder only when more urgent
   function automatic logic prio_beats(input logic ch_vld, input logic [15:0] ch_prio,
                                       input logic hd_vld, input logic [15:0] hd_prio);
      return ch_vld && (!hd_vld || (ch_prio < hd_prio));
   endfunction
endpackage

// File: rtl/arb_cand_tree.sv
`timescale 1ns/1ps
module arb_cand_tree #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned ID_W    = 10
) (
   input  logic [NUM_SRC-1:0]        cand,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      win_vld,
   output logic [PRIO_W-1:0]         win_prio,
   output logic [ID_W-1:0]           win_id
);
   import irq_arb_pkg::*;
   localparam int unsigned LVL   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned NP2   = 1 << LVL;
   localparam int unsigned NODES = 2 * NP2;

   logic              nd_v [1:NODES-1];
   logic [PRIO_W-1:0] nd_p [1:NODES-1];
   logic [ID_W-1:0]   nd_i [1:NODES-1];

   genvar j, k;
   generate
      for (j = 0; j < NP2; j++) begin : g_leaf
         if (j < NUM_SRC) begin : g_real
            assign nd_v[NP2+j] = cand[j];
            assign nd_p[NP2+j] = prio[j*PRIO_W +: PRIO_W];
            assign nd_i[NP2+j] = ID_W'(j);
         end else begin : g_pad
            assign nd_v[NP2+j] = 1'b0;
            assign nd_p[NP2+j] = '1;
            assign nd_i[NP2+j] = '0;
         end
      end
      // left child always holds the lower IDs, so it keeps ties
      for (k = 1; k < NP2; k++) begin : g_node
         logic take_r;
         assign take_r  = prio_beats(nd_v[2*k+1], 16'(nd_p[2*k+1]),
                                     nd_v[2*k],   16'(nd_p[2*k]));
         assign nd_v[k] = nd_v[2*k] | nd_v[2*k+1];
         assign nd_p[k] = take_r ? nd_p[2*k+1] : nd_p[2*k];
         assign nd_i[k] = take_r ? nd_i[2*k+1] : nd_i[2*k];
      end
   endgenerate

   assign win_vld  = nd_v[1];
   assign win_prio = nd_p[1];
   assign win_id   = nd_i[1];
endmodule

// File: rtl/arb_cand_linear.sv
`timescale 1ns/1ps
module arb_cand_linear #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned ID_W    = 10
) (
   input  logic [NUM_SRC-1:0]        cand,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      win_vld,
   output logic [PRIO_W-1:0]         win_prio,
   output logic [ID_W-1:0]           win_id
);
   import irq_arb_pkg::*;

   // ascending scan, strict compare: first of equals is kept
   always_comb begin
      win_vld  = 1'b0;
      win_prio = '1;
      win_id   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (prio_beats(cand[s], 16'(prio[s*PRIO_W +: PRIO_W]), win_vld, 16'(win_prio))) begin
            win_vld  = 1'b1;
            win_prio = prio[s*PRIO_W +: PRIO_W];
            win_id   = ID_W'(s);
         end
      end
   end
endmodule

// File: rtl/arb_gate.sv
`timescale 1ns/1ps
module arb_gate #(
   parameter int unsigned PRIO_W = 8,
   parameter int unsigned ID_W   = 10
) (
   input  logic              dist_en,
   input  logic              cpu_en,
   input  logic              win_vld,
   input  logic [PRIO_W-1:0] win_prio,
   input  logic [ID_W-1:0]   win_id,
   input  logic [PRIO_W-1:0] mask,
   input  logic [PRIO_W:0]   run,
   output logic [ID_W-1:0]   id_d,
   output logic              irq_d
);
   import irq_arb_pkg::*;
   logic below_mask, below_run, shown;

   assign below_mask = win_prio < mask;
   assign below_run  = {1'b0, win_prio} < run;
   assign shown      = dist_en && cpu_en && win_vld && below_mask;
   assign id_d       = shown ? win_id : ID_W'(SPURIOUS_ID);
   assign irq_d      = shown && below_run;
endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter #(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_CPU   = 2,
   parameter int unsigned PRIO_W    = 8,
   parameter int unsigned ID_W      = 10,
   parameter bit          SCAN_TREE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dist_en,
   input  logic [NUM_CPU-1:0]            cpu_en,
   input  logic [NUM_CPU*NUM_SRC-1:0]    src_enable,
   input  logic [NUM_CPU*NUM_SRC-1:0]    src_pending,
   input  logic [NUM_SRC*PRIO_W-1:0]     src_prio,
   input  logic [NUM_CPU*PRIO_W-1:0]     prio_mask,
   input  logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
   output logic [NUM_CPU*ID_W-1:0]       hp_id,
   output logic [NUM_CPU-1:0]            cpu_irq
);
   import irq_arb_pkg::*;
   localparam int unsigned RUN_W = PRIO_W + 1;

   initial begin
      chk_src_range : assert (NUM_SRC >= 2 && NUM_SRC < SPURIOUS_ID)
         else $error("NUM_SRC out of range");
      chk_cpu_range : assert (NUM_CPU >= 1) else $error("NUM_CPU must be at least 1");
      chk_id_width  : assert (ID_W >= MIN_ID_W) else $error("ID_W too narrow for spurious ID");
      chk_prio_w    : assert (PRIO_W >= 1 && PRIO_W <= 15) else $error("PRIO_W out of range");
   end

   genvar c;
   generate
      for (c = 0; c < NUM_CPU; c++) begin : g_cpu
         logic [NUM_SRC-1:0] cand;
         logic               w_vld;
         logic [PRIO_W-1:0]  w_prio;
         logic [ID_W-1:0]    w_id;
         logic [ID_W-1:0]    id_d;
         logic               irq_d;

         assign cand = src_enable[c*NUM_SRC +: NUM_SRC] & src_pending[c*NUM_SRC +: NUM_SRC];

         if (SCAN_TREE) begin : g_tree
            arb_cand_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_sel (
               .cand(cand), .prio(src_prio),
               .win_vld(w_vld), .win_prio(w_prio), .win_id(w_id));
         end else begin : g_linear
            arb_cand_linear #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_sel (
               .cand(cand), .prio(src_prio),
               .win_vld(w_vld), .win_prio(w_prio), .win_id(w_id));
         end

         arb_gate #(.PRIO_W(PRIO_W), .ID_W(ID_W)) i_gate (
            .dist_en (dist_en),
            .cpu_en  (cpu_en[c]),
            .win_vld (w_vld),
            .win_prio(w_prio),
            .win_id  (w_id),
            .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
            .run     (run_prio[c*RUN_W +: RUN_W]),
            .id_d    (id_d),
            .irq_d   (irq_d));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hp_id[c*ID_W +: ID_W] <= ID_W'(SPURIOUS_ID);
               cpu_irq[c]            <= 1'b0;
            end else begin
               hp_id[c*ID_W +: ID_W] <= id_d;
               cpu_irq[c]            <= irq_d;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
`timescale 1ns/1ps
module irq_prio_arbiter_chk #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NUM_CPU = 2,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned ID_W    = 10
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          dist_en,
   input logic [NUM_CPU-1:0]            cpu_en,
   input logic [NUM_CPU*NUM_SRC-1:0]    src_enable,
   input logic [NUM_CPU*NUM_SRC-1:0]    src_pending,
   input logic [NUM_SRC*PRIO_W-1:0]     src_prio,
   input logic [NUM_CPU*PRIO_W-1:0]     prio_mask,
   input logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
   input logic [NUM_CPU*ID_W-1:0]       hp_id,
   input logic [NUM_CPU-1:0]            cpu_irq
);
   localparam int unsigned RUN_W = PRIO_W + 1;
   localparam logic [ID_W-1:0] SPUR = ID_W'(1023);

   logic                          prev_ok;
   logic                          p_dist;
   logic [NUM_CPU-1:0]            p_cpu;
   logic [NUM_CPU*NUM_SRC-1:0]    p_en, p_pend;
   logic [NUM_SRC*PRIO_W-1:0]     p_prio;
   logic [NUM_CPU*PRIO_W-1:0]     p_mask;
   logic [NUM_CPU*RUN_W-1:0]      p_run;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_ok <= 1'b0;
      else        prev_ok <= 1'b1;
      p_dist <= dist_en;
      p_cpu  <= cpu_en;
      p_en   <= src_enable;
      p_pend <= src_pending;
      p_prio <= src_prio;
      p_mask <= prio_mask;
      p_run  <= run_prio;
   end

   genvar c;
   generate
      for (c = 0; c < NUM_CPU; c++) begin : g_cpu
         logic [ID_W-1:0]   id_now;
         logic              is_real;
         int unsigned       idx;
         logic [PRIO_W-1:0] w_prio;

         assign id_now  = hp_id[c*ID_W +: ID_W];
         assign is_real = id_now != SPUR;
         assign idx     = (32'(id_now) < NUM_SRC) ? 32'(id_now) : 0;
         assign w_prio  = p_prio[idx*PRIO_W +: PRIO_W];

         assert_id_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            is_real |-> (32'(id_now) < NUM_SRC));
         assert_irq_needs_id_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> is_real);
         assert_cand_R1 : assert property (@(posedge clk) disable iff (!rst_n || !prev_ok)
            is_real |-> (p_en[c*NUM_SRC + idx] && p_pend[c*NUM_SRC + idx]));
         assert_mask_R7 : assert property (@(posedge clk) disable iff (!rst_n || !prev_ok)
            is_real |-> (w_prio < p_mask[c*PRIO_W +: PRIO_W]));
         assert_run_R8 : assert property (@(posedge clk) disable iff (!rst_n || !prev_ok)
            cpu_irq[c] |-> ({1'b0, w_prio} < p_run[c*RUN_W +: RUN_W]));
         assert_dist_off_R5 : assert property (@(posedge clk) disable iff (!rst_n || !prev_ok)
            !p_dist |-> (!cpu_irq[c] && !is_real));
         assert_cpu_off_R6 : assert property (@(posedge clk) disable iff (!rst_n || !prev_ok)
            !p_cpu[c] |-> (!cpu_irq[c] && !is_real));
      end
   endgenerate
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
   .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .ID_W(ID_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
   .src_enable(src_enable), .src_pending(src_pending), .src_prio(src_prio),
   .prio_mask(prio_mask), .run_prio(run_prio), .hp_id(hp_id), .cpu_irq(cpu_irq)
);

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;
   localparam int NS = 64;
   localparam int NC = 2;
   localparam int PW = 8;
   localparam int IW = 10;
   localparam int RW = PW + 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              dist_en;
   logic [NC-1:0]     cpu_en;
   logic [NC*NS-1:0]  en, pend;
   logic [NS*PW-1:0]  prio;
   logic [NC*PW-1:0]  mask;
   logic [NC*RW-1:0]  run;
   logic [NC*IW-1:0]  hp_id;
   logic [NC-1:0]     cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_prio_arbiter #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(PW), .ID_W(IW)) i_irq_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
      .src_enable(en), .src_pending(pend), .src_prio(prio),
      .prio_mask(mask), .run_prio(run), .hp_id(hp_id), .cpu_irq(cpu_irq));

   // arithmetic reference from the requirements
   function automatic void model(input int c, output logic [IW-1:0] id, output logic irq);
      int best_p = 512;
      int best_s = -1;
      for (int s = 0; s < NS; s++) begin
         if (en[c*NS+s] && pend[c*NS+s] && int'(prio[s*PW +: PW]) < best_p) begin
            best_p = int'(prio[s*PW +: PW]);
            best_s = s;
         end
      end
      id  = 10'd1023;
      irq = 1'b0;
      if (dist_en && cpu_en[c] && best_s >= 0 && best_p < int'(mask[c*PW +: PW])) begin
         id  = IW'(best_s);
         irq = best_p < int'(run[c*RW +: RW]);
      end
   endfunction

   task automatic check_cpu(input int c, input string req);
      logic [IW-1:0] eid;
      logic          eirq;
      model(c, eid, eirq);
      checks++;
      if (hp_id[c*IW +: IW] !== eid || cpu_irq[c] !== eirq) begin
         errors++;
         $display("FAIL %s cpu%0d: id=%0d irq=%0b expected id=%0d irq=%0b",
                  req, c, hp_id[c*IW +: IW], cpu_irq[c], eid, eirq);
      end
   endtask

   task automatic check_raw(input int c, input int eid, input logic eirq, input string req);
      checks++;
      if (hp_id[c*IW +: IW] !== IW'(eid) || cpu_irq[c] !== eirq) begin
         errors++;
         $display("FAIL %s cpu%0d: id=%0d irq=%0b expected id=%0d irq=%0b",
                  req, c, hp_id[c*IW +: IW], cpu_irq[c], eid, eirq);
      end
   endtask

   task automatic step_check(input string req);
      @(negedge clk);
      for (int c = 0; c < NC; c++) check_cpu(c, req);
   endtask

   task automatic clear_src();
      en   = '0;
      pend = '0;
      prio = '1;
   endtask

   task automatic add_src(input int c, input int s, input int p);
      en[c*NS+s]       = 1'b1;
      pend[c*NS+s]     = 1'b1;
      prio[s*PW +: PW] = PW'(p);
   endtask

   task automatic open_all();
      dist_en = 1'b1;
      cpu_en  = '1;
      for (int c = 0; c < NC; c++) begin
         mask[c*PW +: PW] = 8'hFF;
         run[c*RW +: RW]  = 9'h100;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      clear_src();
      open_all();
      add_src(0, 3, 8'h10);
      repeat (3) @(negedge clk);
      // R9: reset state while rst_n is low, despite a qualifying source
      check_raw(0, 1023, 1'b0, "R9 reset");
      check_raw(1, 1023, 1'b0, "R9 reset");
      rst_n = 1'b1;
      clear_src();
      step_check("R4 nothing pending");

      // R1: enable-only and pending-only bits are not candidates
      clear_src();
      en[0*NS+9]    = 1'b1; prio[9*PW +: PW]  = 8'h01;
      pend[0*NS+12] = 1'b1; prio[12*PW +: PW] = 8'h01;
      add_src(0, 5, 8'h40);
      en[1*NS+5]    = 1'b1;
      step_check("R1 enable and pending");

      // R2: most urgent wins
      clear_src();
      add_src(0, 2, 8'h80); add_src(0, 40, 8'h20); add_src(0, 61, 8'h50);
      add_src(1, 7, 8'h90); add_src(1, 33, 8'hA0);
      step_check("R2 lowest value wins");
      check_raw(0, 40, 1'b1, "R2 direct");
      check_raw(1, 7, 1'b1, "R2 direct");

      // R3: ties go to the lowest ID
      clear_src();
      add_src(0, 63, 8'h30); add_src(0, 20, 8'h30); add_src(0, 10, 8'h30);
      add_src(1, 0, 8'h30);  add_src(1, 1, 8'h30);
      step_check("R3 tie lowest id");
      check_raw(0, 10, 1'b1, "R3 direct");
      check_raw(1, 0, 1'b1, "R3 direct");

      // R7: mask boundary
      clear_src();
      add_src(0, 17, 8'h60);
      mask[0 +: PW] = 8'h60;
      step_check("R7 prio equals mask");
      check_raw(0, 1023, 1'b0, "R7 equal mask blocked");
      mask[0 +: PW] = 8'h61;
      step_check("R7 prio below mask");
      check_raw(0, 17, 1'b1, "R7 just under mask");
      mask[0 +: PW] = 8'h00;
      add_src(0, 18, 8'h00);
      step_check("R7 zero mask blocks all");

      // R8: running-priority boundary
      open_all();
      clear_src();
      add_src(0, 22, 8'h44);
      run[0 +: RW] = 9'h044;
      step_check("R8 run equal");
      check_raw(0, 22, 1'b0, "R8 reported without request");
      run[0 +: RW] = 9'h045;
      step_check("R8 run above");
      check_raw(0, 22, 1'b1, "R8 request");
      run[0 +: RW] = 9'h100;
      prio[22*PW +: PW] = 8'hFE;
      step_check("R8 idle preempted");
      check_raw(0, 22, 1'b1, "R8 idle 0x100");

      // R5 / R6
      clear_src();
      add_src(0, 4, 8'h10); add_src(1, 6, 8'h10);
      dist_en = 1'b0;
      step_check("R5 distributor off");
      check_raw(1, 1023, 1'b0, "R5 direct");
      dist_en = 1'b1;
      cpu_en  = 2'b01;
      step_check("R6 cpu1 off");
      check_raw(0, 4, 1'b1, "R6 other cpu unaffected");
      check_raw(1, 1023, 1'b0, "R6 disabled cpu");
      cpu_en = 2'b11;

      // R9: latency of exactly one edge
      @(negedge clk);
      clear_src();
      add_src(0, 50, 8'h05);
      #1;
      check_raw(0, 4, 1'b1, "R9 holds before edge");
      @(negedge clk);
      check_raw(0, 50, 1'b1, "R9 updates after edge");

      // random sweep, few priority levels so ties are common
      for (int n = 0; n < 3000; n++) begin
         dist_en = ($urandom % 16) != 0;
         cpu_en  = NC'($urandom % 4) | ((($urandom % 4) != 0) ? 2'b11 : 2'b00);
         for (int i = 0; i < NC*NS; i++) begin
            en[i]   = ($urandom % 3) != 0;
            pend[i] = ($urandom % 4) == 0;
         end
         for (int s = 0; s < NS; s++) prio[s*PW +: PW] = PW'(($urandom % 5) * 8'h30);
         for (int c = 0; c < NC; c++) begin
            mask[c*PW +: PW] = PW'($urandom);
            run[c*RW +: RW]  = (($urandom % 3) == 0) ? 9'h100 : RW'($urandom);
         end
         step_check("R2 R3 R7 R8 sweep");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule